// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a 4096-byte serial memory that sits on a two-wire bus. A system clock oversamples the bus clock (SCL) and data (SDA) lines. The engine pulls SDA low through an active-low output enable, so the line is treated as open-drain. It frames transactions on start and stop conditions and accepts only one fixed device address. It takes a 12-bit word address sent in two bytes. It serves current, random and sequential reads from an internal byte array that holds all ones after reset.

Every data byte written by the bus master is acknowledged. Each one is issued for one cycle on a write port, together with its target address, for a separate write-cycle block to take. The same port also updates the internal array, so later reads return the new value.

The engine keeps one address register. A read moves it one past the byte just read. A write leaves it on the last byte written. Within one write transaction, only the low five address bits advance, so the write stays inside a 32-byte page.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset SDA is released and no write is issued. The engine ignores all bus traffic until a start (SDA falling while SCL is high) has been seen.
- R2: The engine acknowledges the first byte after a start only if its upper seven bits are 1010000. Bit 0 selects the operation: 0 is write or address load, 1 is read. A byte with any other upper bits gets no acknowledge, and every byte after it is ignored until the next start.
- R3: The two bytes after a write-selecting device byte form the word address. The low nibble of the first byte gives bits 11..8 and its upper nibble is ignored. The second byte gives bits 7..0. Both bytes are acknowledged.
- R4: Each data byte after the word address is acknowledged. In the same cycle that SDA is pulled low for the acknowledge, the byte appears on the write port with a one-cycle valid. The first data byte goes to the loaded address. Each later byte goes to the previous address with its low five bits incremented, wrapping inside the 32-byte page.
- R5: In a read, the engine sends 8 bits MSB first. It changes SDA only after a falling SCL edge, so SDA is stable while SCL is high. It releases SDA for the master's acknowledge slot.
- R6: A low acknowledge from the master makes the engine send the byte at the next address. A high acknowledge ends the read. The engine then leaves SDA released through further clocks until a stop, and a new start reopens it.
- R7: A read that starts without a new address (current read) begins at the address register. After a read this register holds the last read address plus one. After a write it holds the last written address.
- R8: Every location reads FFh until written. A sequential read steps past address 4095 to address 0.
- R9: A start in the middle of a byte drops the partial byte and restarts device address matching.
- R10: A stop (SDA rising while SCL is high) returns the engine to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_n | output | 1 | Low pulls SDA low; high releases the line |
| wr_valid | output | 1 | One-cycle pulse carrying a received write byte |
| wr_addr | output | 12 | Target address of the write byte |
| wr_data | output | 8 | Write byte value |

## Verification
The bench writes across a page end and checks that the third byte wraps to the page base. A design that carried into bit 5 would put that byte on the next page. Reads that follow writes and reads that follow reads tell apart a register that always advances from one that stays put after writes. A sequential read across 4095 catches a counter that saturates or skips. The bench also sends bytes with no start, a wrong device address, traffic after a master's no-acknowledge, and a start part way through a byte. A design that acknowledged any of these, or kept a stale bit count, would pull SDA low where the bench expects it high.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

    // Protocol phases of the engine
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a start
        ST_DEV   = 3'd1,  // receiving the device byte
        ST_AHI   = 3'd2,  // receiving address high bits
        ST_ALO   = 3'd3,  // receiving address low byte
        ST_WDAT  = 3'd4,  // receiving write data
        ST_READ  = 3'd5,  // transmitting read data
        ST_WAIT  = 3'd6   // read ended, waiting for stop
    } phase_e;

endpackage

// File: rtl/sms_sync.sv
module sms_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // bit 1 carries SCL, bit 0 carries SDA
    logic [1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sda_lvl   = sync_q[0];
    assign scl_rise  = sync_q[1] & ~prev_q[1];
    assign scl_fall  = ~sync_q[1] & prev_q[1];
    assign start_det = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
    assign stop_det  = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];

endmodule

// File: rtl/sms_array.sv
module sms_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '1;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import serial_mem_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          PAGE_W = 5,
    parameter logic [6:0]  DEV_ID = 7'b1010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int              HI_W  = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] A_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [PAGE_W-1:0] P_ONE = {{(PAGE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e            st;
        phase_e            nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              ack_ph;
        logic              drv;
        logic              macked;
        logic              first;
        logic [HI_W-1:0]   hi;
        logic [ADDR_W-1:0] ptr;
        logic              wr_v;
        logic [ADDR_W-1:0] wr_a;
        logic [7:0]        wr_d;
    } regs_t;

    regs_t q, d;

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        rd_byte;
    logic [ADDR_W-1:0] page_nxt;

    sms_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sms_array #(.AW(ADDR_W), .DW(8)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (q.wr_v),
        .waddr (q.wr_a),
        .wdata (q.wr_d),
        .raddr (q.ptr),
        .rdata (rd_byte)
    );

    // next write slot: low page bits advance, upper bits hold
    assign page_nxt = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + P_ONE};

    always_comb begin
        d      = q;
        d.wr_v = 1'b0;
        if (start_det) begin
            d.st     = ST_DEV;
            d.cnt    = 4'd0;
            d.ack_ph = 1'b0;
            d.drv    = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.cnt    = 4'd0;
            d.ack_ph = 1'b0;
            d.drv    = 1'b0;
        end else begin
            case (q.st)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (q.ack_ph) begin
                        if (scl_fall) begin
                            d.ack_ph = 1'b0;
                            d.drv    = 1'b0;
                            d.cnt    = 4'd0;
                            d.st     = q.nxt;
                            if (q.nxt == ST_READ) begin
                                d.sh  = rd_byte;
                                d.drv = ~rd_byte[7];
                            end
                        end
                    end else if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.ack_ph = 1'b1;
                        d.drv    = 1'b1;
                        case (q.st)
                            ST_DEV: begin
                                if (q.sh[7:1] == DEV_ID) begin
                                    d.nxt   = q.sh[0] ? ST_READ : ST_AHI;
                                    d.first = 1'b1;
                                end else begin
                                    d.st     = ST_IDLE;
                                    d.ack_ph = 1'b0;
                                    d.drv    = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                d.hi  = q.sh[HI_W-1:0];
                                d.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                d.ptr = {q.hi, q.sh};
                                d.nxt = ST_WDAT;
                            end
                            default: begin
                                d.first = 1'b0;
                                d.ptr   = q.first ? q.ptr : page_nxt;
                                d.wr_v  = 1'b1;
                                d.wr_a  = d.ptr;
                                d.wr_d  = q.sh;
                                d.nxt   = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_READ: begin
                    if (q.ack_ph) begin
                        if (scl_rise) begin
                            d.macked = ~sda_lvl;
                        end else if (scl_fall) begin
                            d.ack_ph = 1'b0;
                            if (q.macked) begin
                                d.sh  = rd_byte;
                                d.drv = ~rd_byte[7];
                                d.cnt = 4'd0;
                            end else begin
                                d.st = ST_WAIT;
                            end
                        end
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.drv    = 1'b0;
                            d.ack_ph = 1'b1;
                            d.cnt    = 4'd0;
                            d.ptr    = q.ptr + A_ONE;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.drv = ~q.sh[6];
                            d.sh  = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_n = ~q.drv;
    assign wr_valid = q.wr_v;
    assign wr_addr  = q.wr_a;
    assign wr_data  = q.wr_d;

endmodule

// File: rtl/sms_chk.sv
module sms_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe_n,
    input logic wr_valid,
    input logic scl_fall,
    input logic start_det,
    input logic stop_det
);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> sda_oe_n);

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> sda_oe_n);

    // R5
    drive_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_n) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R4
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !sda_oe_n);

    // R4
    write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

bind serial_mem_slave sms_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe_n  (sda_oe_n),
    .wr_valid  (wr_valid),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_oe_n, wr_valid;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;

    int total = 0, bad = 0, glitch = 0, wcnt = 0, exp_ptr = 0;
    bit done = 1'b0;
    logic [7:0]  mdl [4096];
    logic [11:0] cap_a [64];
    logic [7:0]  cap_d [64];

    assign sda_bus = sda_m & sda_oe_n;
    always #2 clk = ~clk;

    serial_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_n(sda_oe_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (wcnt < 64) begin
                cap_a[wcnt] = wr_addr;
                cap_d[wcnt] = wr_data;
            end
            wcnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic s);
        logic s1;
        sda_m = b; w(4);
        scl = 1'b1; w(2);
        s1 = sda_bus; w(4);
        s = sda_bus;
        if (s1 !== s) glitch++;
        w(2);
        scl = 1'b0; w(4);
    endtask

    task automatic do_start;
        sda_m = 1'b1; w(4);
        scl = 1'b1; w(8);
        sda_m = 1'b0; w(8);
        scl = 1'b0; w(4);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; w(4);
        scl = 1'b1; w(8);
        sda_m = 1'b1; w(8);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_x(b[i], s);
        bit_x(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, s);
            v[i] = s;
        end
        bit_x(~mack, s);
    endtask

    // write n bytes from address a; junk fills the ignored upper nibble
    task automatic page_wr(input logic [11:0] a, input logic [3:0] junk,
                           input int n, input logic [7:0] seed);
        logic ack;
        logic [11:0] ea;
        logic [7:0] dv;
        int base;
        base = wcnt;
        do_start;
        send(8'hA0, ack); check("R2 device write ack", ack, 1);
        send({junk, a[11:8]}, ack); check("R3 addr hi ack", ack, 1);
        send(a[7:0], ack); check("R3 addr lo ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            dv = seed + 8'(k * 37);
            ea = {a[11:5], 5'(a[4:0] + 5'(k))};
            send(dv, ack); check("R4 data ack", ack, 1);
            mdl[ea] = dv;
            exp_ptr = int'(ea);
            if (base + k < 64) begin
                w(1);
                check("R4 write addr", cap_a[base + k], ea);
                check("R4 write data", cap_d[base + k], dv);
            end
        end
        do_stop;
        check("R4 write count", wcnt - base, n);
    endtask

    // read n bytes from the current address (acks all but the last)
    task automatic rd_seq(input int n, input string req);
        logic ack;
        logic [7:0] v;
        do_start;
        send(8'hA1, ack); check("R2 device read ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv(k < n - 1, v);
            check(req, v, mdl[exp_ptr]);
            exp_ptr = (exp_ptr + 1) % 4096;
        end
    endtask

    task automatic set_addr(input logic [11:0] a);
        logic ack;
        do_start;
        send(8'hA0, ack); check("R2 device ack", ack, 1);
        send({4'h6, a[11:8]}, ack); check("R3 addr hi ack", ack, 1);
        send(a[7:0], ack); check("R3 addr lo ack", ack, 1);
        exp_ptr = int'(a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] v;
        int lows;
        for (int i = 0; i < 4096; i++) mdl[i] = 8'hFF;
        w(3);
        rst_n = 1'b1;
        w(2);
        check("R1 reset sda released", sda_oe_n, 1);
        check("R1 reset no write", wr_valid, 0);

        // R1: a matching byte with no preceding start is ignored
        send(8'hA0, ack); check("R1 no start no ack", ack, 0);

        // R3/R4: upper nibble ignored, two byte write
        page_wr(12'h123, 4'hF, 2, 8'h5A);
        // R7: current read after write returns last written byte
        rd_seq(1, "R7 read after write"); do_stop;
        // R7/R8: next current read returns n+1, untouched reads FFh
        rd_seq(1, "R8 erased FF / R7 n+1"); do_stop;

        // R4: page wrap within 32 bytes
        page_wr(12'h7FE, 4'hA, 3, 8'h11);
        // R6: sequential read past page end, then silence after no-ack
        set_addr(12'h7FE);
        rd_seq(3, "R6 sequential read");
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            bit_x(1'b1, s);
            if (!s) lows++;
        end
        check("R6 silent after no-ack", lows, 0);
        do_stop;

        // R8: counter wraps 4095 -> 0
        page_wr(12'h000, 4'h0, 1, 8'h44);
        page_wr(12'hFFF, 4'h5, 1, 8'h99);
        set_addr(12'hFFF);
        rd_seq(2, "R8 wrap read"); do_stop;

        // R2: wrong select bits, then wrong identifier
        do_start;
        send(8'hA2, ack); check("R2 wrong select no ack", ack, 0);
        send(8'hA0, ack); check("R2 ignored until start", ack, 0);
        do_stop;
        do_start;
        send(8'h21, ack); check("R2 wrong id no ack", ack, 0);
        do_stop;

        // R9: start in mid byte restarts matching
        do_start;
        bit_x(1'b1, s); bit_x(1'b0, s); bit_x(1'b1, s);
        do_start;
        send(8'hA1, ack); check("R9 restart ack", ack, 1);
        recv(1'b0, v); check("R9 read after restart", v, mdl[exp_ptr]);
        exp_ptr = (exp_ptr + 1) % 4096;
        do_stop;

        // R10: stop releases and returns to idle
        do_start;
        send(8'hA0, ack); check("R10 ack before stop", ack, 1);
        do_stop;
        w(4);
        check("R10 released after stop", sda_oe_n, 1);
        send(8'hA0, ack); check("R10 idle after stop", ack, 0);

        check("R5 sda stable while scl high", glitch, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule